// File: doc/BRIEF.md
# Latched Security Loop Alarm Controller

This block guards a normally closed security loop. The loop input is high while the loop is intact. When the loop is broken, the block sets an alarm latch and drives the alarm output. The alarm then stays on even if the loop is closed again, so a brief break cannot cancel it.

While the alarm is on, a timeout counter advances on every clock cycle where the prescaler tick enable is high. Its width is set by a stage-count parameter. When the counter wraps, the alarm is silenced and a one-cycle timeout strobe is raised, provided the loop has been restored by then. If the loop is still open at the wrap, the counter starts a fresh period and the alarm stays on. While the alarm is off, the counter is held at zero.

An asynchronous active-low reset clears all state. The loop input is asynchronous and passes through a two-flop synchroniser before the latch sees it.

Top module: `loop_alarm_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, alarm and timeout are 0; a reset asserted during an active alarm clears it at once.
- R2: The alarm output rises on the third rising clock edge after loop_ok is driven low (two synchroniser flops, then the latch).
- R3: Once set, the alarm stays high after loop_ok returns high; it falls only at a timeout.
- R4: The counter advances only on cycles with tick_en high. An alarm raised and then left with the loop closed stays high for exactly 2^STAGES tick cycles.
- R5: At the wrap with the synchronised loop closed, the alarm falls on that edge, and timeout is high for exactly that one following cycle.
- R6: At the wrap with the synchronised loop still open, the alarm stays high, no timeout pulse occurs, and a fresh full period of 2^STAGES ticks begins.
- R7: Ticks seen while the alarm is off have no effect: the next alarm period is still a full 2^STAGES ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_ok | input | 1 | Asynchronous loop sense, 1 = loop closed |
| tick_en | input | 1 | Prescaler tick; the timeout counter advances when high |
| alarm | output | 1 | Alarm drive, 1 = alarm on |
| timeout | output | 1 | One-cycle strobe when the alarm is silenced by timeout |

## Verification
The bench builds the block with STAGES = 4, which gives a 16-tick alarm period. With that period, many complete timeouts and wraps with the loop still open fit into a short run. Directed phases cover:
- a short break followed by a restore,
- a break held open across several wraps,
- a period with tick_en low, which stretches the alarm,
- ticks applied while the alarm is idle,
- a reset during an alarm.

A long random phase then toggles loop_ok and tick_en, so that loop changes land close to the wrap cycle.

// File: rtl/loop_alarm_pkg.sv
package loop_alarm_pkg;
  typedef struct packed {
    logic cntClear;
    logic cntAdvance;
  } ctrlStrobes_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } alarmState_t;
endpackage

// File: rtl/loop_alarm_dp.sv
module loop_alarm_dp
  import loop_alarm_pkg::*;
#(
  parameter int STAGES      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loopOkAsync,
  input  ctrlStrobes_t      strobes,
  output logic              loopOpenSync,
  output logic              countAtMax,
  output logic [STAGES-1:0] countValue
);
  localparam logic [STAGES-1:0] COUNT_MAX = {STAGES{1'b1}};

  logic [SYNC_STAGES-1:0] syncChain;
  logic [STAGES-1:0]      count;

  // Synchroniser chain; resets to "loop closed" so reset never raises alarm.
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncChain[0] <= 1'b1;
          else        syncChain[0] <= loopOkAsync;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncChain[g] <= 1'b1;
          else        syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (strobes.cntClear)   count <= '0;
    else if (strobes.cntAdvance) count <= count + 1'b1;
  end

  assign loopOpenSync = ~syncChain[SYNC_STAGES-1];
  assign countAtMax   = (count == COUNT_MAX);
  assign countValue   = count;
endmodule

// File: rtl/loop_alarm_fsm.sv
module loop_alarm_fsm
  import loop_alarm_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         loopOpen,
  input  logic         tickEn,
  input  logic         countAtMax,
  output ctrlStrobes_t strobes,
  output logic         alarmOn,
  output logic         timeoutPulse
);
  alarmState_t state, stateNext;
  logic        wrapHit;
  logic        silence;
  logic        timeoutQ;

  assign wrapHit = (state == ST_ACTIVE) && tickEn && countAtMax;
  assign silence = wrapHit && !loopOpen;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (loopOpen) stateNext = ST_ACTIVE;
      ST_ACTIVE: if (silence)  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.cntAdvance = (state == ST_ACTIVE) && tickEn;
    strobes.cntClear   = (state == ST_IDLE) || wrapHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      timeoutQ <= 1'b0;
    end else begin
      state    <= stateNext;
      timeoutQ <= silence;
    end
  end

  assign alarmOn      = (state == ST_ACTIVE);
  assign timeoutPulse = timeoutQ;
endmodule

// File: rtl/loop_alarm_ctrl.sv
module loop_alarm_ctrl
  import loop_alarm_pkg::*;
#(
  parameter int STAGES = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_ok,
  input  logic tick_en,
  output logic alarm,
  output logic timeout
);
  ctrlStrobes_t      strobes;
  logic              loopOpenSync;
  logic              countAtMax;
  logic [STAGES-1:0] dpCount;

  loop_alarm_dp #(.STAGES(STAGES), .SYNC_STAGES(2)) uDp (
    .clk          (clk),
    .rst_n        (rst_n),
    .loopOkAsync  (loop_ok),
    .strobes      (strobes),
    .loopOpenSync (loopOpenSync),
    .countAtMax   (countAtMax),
    .countValue   (dpCount)
  );

  loop_alarm_fsm uFsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .loopOpen     (loopOpenSync),
    .tickEn       (tick_en),
    .countAtMax   (countAtMax),
    .strobes      (strobes),
    .alarmOn      (alarm),
    .timeoutPulse (timeout)
  );
endmodule

// File: rtl/loop_alarm_chk.sv
module loop_alarm_chk #(
  parameter int STAGES = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              alarm,
  input logic              timeout,
  input logic [STAGES-1:0] count
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!alarm && !timeout));

  // R3
  fall_needs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> timeout);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R5
  pulse_alarm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !alarm);

  // R4
  tick_gates_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));

  // R7
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm |-> (count == '0));

  // R6
  start_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (count == '0));
endmodule

bind loop_alarm_ctrl loop_alarm_chk #(.STAGES(STAGES)) uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .alarm   (alarm),
  .timeout (timeout),
  .count   (dpCount)
);

// File: tb/sim_loop_alarm_ctrl.sv
`timescale 1ns/1ps
module sim_loop_alarm_ctrl;
  localparam int STAGES = 4;
  localparam int MAXC   = (1 << STAGES) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_ok = 1'b1;
  logic tick_en = 1'b0;
  logic alarm;
  logic timeout;

  int vectors = 0;
  int errors  = 0;
  string tag = "R1";

  // reference model state
  logic mS1, mS2, mOn, mTo;
  int   mCnt;

  always #5 clk = ~clk;

  loop_alarm_ctrl #(.STAGES(STAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .loop_ok(loop_ok), .tick_en(tick_en),
    .alarm(alarm), .timeout(timeout)
  );

  function automatic void modelReset();
    mS1 = 1'b1; mS2 = 1'b1; mOn = 1'b0; mTo = 1'b0; mCnt = 0;
  endfunction

  function automatic void modelStep(input logic lp, input logic tk);
    logic open;
    open = !mS2;
    mTo  = 1'b0;
    if (!mOn) begin
      mCnt = 0;
      mOn  = open;
    end else if (tk) begin
      if (mCnt == MAXC) begin
        mCnt = 0;
        mOn  = open;
        mTo  = !open;
      end else begin
        mCnt = mCnt + 1;
      end
    end
    mS2 = mS1;
    mS1 = lp;
  endfunction

  task automatic cycle(input logic lp, input logic tk, input logic rs);
    @(negedge clk);
    vectors++;
    if (alarm !== mOn || timeout !== mTo) begin
      errors++;
      $display("FAIL %s: alarm/timeout got %0b/%0b expected %0b/%0b at %0t",
               tag, alarm, timeout, mOn, mTo, $time);
    end
    loop_ok = lp; tick_en = tk; rst_n = rs;
    if (!rs) modelReset();
    else     modelStep(lp, tk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b1);
    // R2 and R3: short break then restore, alarm must latch
    tag = "R2";
    for (int i = 0; i < 2; i++) cycle(1'b0, 1'b1, 1'b1);
    tag = "R3";
    for (int i = 0; i < 8; i++) cycle(1'b1, 1'b1, 1'b1);
    // R5: timeout with the loop closed
    tag = "R5";
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b1, 1'b1);
    // R6: loop held open across several wraps
    tag = "R6";
    for (int i = 0; i < 50; i++) cycle(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 1'b1);
    // R4: tick_en low stretches the alarm
    tag = "R4";
    cycle(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b1, (i % 3) == 0, 1'b1);
    // R7: ticks while idle do not shorten the next period
    tag = "R7";
    for (int i = 0; i < 25; i++) cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 25; i++) cycle(1'b1, 1'b1, 1'b1);
    // R1: reset during an active alarm
    tag = "R1";
    cycle(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    cycle(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b1);
    // random mix, loop changes near wrap boundaries
    tag = "R6";
    begin
      logic lp;
      lp = 1'b1;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 15) == 0) lp = ~lp;
        cycle(lp, $urandom_range(0, 1) == 1, 1'b1);
      end
    end
    cycle(1'b1, 1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule